// File: doc/BRIEF.md
# Fly-by DMA Channel Engine

This block is a single DMA channel that moves bytes between a serial FIFO and memory in fly-by fashion. It drives only the memory address; the data moves directly between the FIFO and memory, and the channel never holds it. Software loads a start address and a block length, picks the address direction, and then enables the channel. While the channel is enabled and its FIFO holds data, it requests the bus.

Once the bus is granted, the channel keeps it and issues one address per transfer until the FIFO runs dry. It does not release the bus after each byte. A transfer cycle is always followed by one gap cycle, so the FIFO flags have time to settle. Each transfer moves the address up or down by one and lowers the remaining count by one. When the count reaches zero, the channel raises terminal count, disables itself, and can raise an interrupt. A software abort stops the channel once the transfer in flight has finished.

Top module: `flyby_dma_chan`

## Requirements
- R1: During and after a synchronous reset, every output is 0 until software writes something.
- R2: `bus_req` rises one cycle after the channel is enabled with the FIFO non-empty. It never rises while the channel is disabled.
- R3: Transfers present the loaded address first. After each transfer the address moves by one: it increments when control bit 1 (`wdata[1]`) is 0 and decrements when it is 1. The address wraps modulo 2^ADDR_W.
- R4: `xfer_valid` is a one-cycle pulse, and two pulses are never in adjacent cycles.
- R5: After a grant, the channel holds `bus_req` and keeps transferring until the FIFO drains. It pulses `fifo_drained` on the transfer made with `fifo_last` high, then drops `bus_req`.
- R6: `cur_count` falls by exactly one for each transfer. Loading the count overrides a decrement in the same cycle.
- R7: When a transfer takes the count from 1 to 0, `tc_flag` sets, the enable clears, and `bus_req` falls on the same clock edge.
- R8: `irq` equals `tc_flag` AND the interrupt enable (control bit 2). A `wr_clr` write with `wdata[0]=1` clears `tc_flag`; one with `wdata[1]=1` clears `abort_flag`.
- R9: A pulse on `abort_req` clears the enable and sets `abort_flag`. Only a transfer in the same cycle may still complete; no transfer follows it.
- R10: A control write with enable (bit 0) set is ignored while the count is zero.
- R11: When the last FIFO byte is also the terminal-count transfer, both `tc_flag` and `fifo_drained` are reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr | input | 1 | Load start address from `wdata` |
| wr_count | input | 1 | Load block length from `wdata[CNT_W-1:0]` |
| wr_ctrl | input | 1 | Write control: bit0 enable, bit1 decrement, bit2 irq enable |
| wr_clr | input | 1 | Write-one-to-clear status: bit0 terminal count, bit1 abort |
| wdata | input | ADDR_W | Software write data |
| abort_req | input | 1 | Abort the channel after the current transfer |
| fifo_ready | input | 1 | FIFO holds at least one byte |
| fifo_last | input | 1 | FIFO holds exactly one byte |
| bus_grant | input | 1 | Bus granted to this channel |
| bus_req | output | 1 | Bus request |
| xfer_valid | output | 1 | Transfer cycle strobe |
| xfer_addr | output | ADDR_W | Address of the current transfer |
| fifo_drained | output | 1 | Pulse: service ended on the last FIFO byte |
| tc_flag | output | 1 | Terminal count status (sticky) |
| abort_flag | output | 1 | Abort status (sticky) |
| irq | output | 1 | Interrupt request |
| chan_en | output | 1 | Channel enable state |
| cur_addr | output | ADDR_W | Next address to be issued |
| cur_count | output | CNT_W | Transfers remaining |

## Verification
The hardest cases to reach from the ports are the ones where two end conditions land on the same transfer. One is terminal count coinciding with the final FIFO byte. The other is an abort arriving while a burst is in progress. The bench models the FIFO as a counter that pops on each `xfer_valid`. It sizes the FIFO contents and the block length to be equal to force the coincident ending. It fires the abort mid-burst, then checks the remaining count against the transfers actually seen and confirms that no further address appears.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  localparam int CTL_EN    = 0;
  localparam int CTL_DEC   = 1;
  localparam int CTL_IRQEN = 2;
  localparam int CLR_TC    = 0;
  localparam int CLR_ABT   = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2,
    ST_COOL = 2'd3
  } chan_state_t;
endpackage

// File: rtl/fdma_addr_ctr.sv
module fdma_addr_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         down,
  output logic [W-1:0] addr
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= down ? addr - ONE : addr + ONE;
  end
endmodule

// File: rtl/fdma_len_ctr.sv
module fdma_len_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         is_one,
  output logic         is_zero
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (dec && !is_zero) cnt <= cnt - ONE;
  end

  assign is_one  = (cnt == ONE);
  assign is_zero = (cnt == '0);
endmodule

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
  import fdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_count,
  input  logic              wr_ctrl,
  input  logic              wr_clr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              abort_req,
  input  logic              fifo_ready,
  input  logic              fifo_last,
  input  logic              bus_grant,
  output logic              bus_req,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              fifo_drained,
  output logic              tc_flag,
  output logic              abort_flag,
  output logic              irq,
  output logic              chan_en,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_count
);
  chan_state_t st_q, st_n;
  logic dec_q, irq_en_q;
  logic en_n, dec_n, irq_en_n, tc_n, abt_n, req_n, drain_n;
  logic do_xfer, tc_hit, cnt_one, cnt_zero, in_service_n;

  fdma_addr_ctr #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(wr_addr), .load_val(wdata),
    .step(do_xfer), .down(dec_q), .addr(cur_addr)
  );

  fdma_len_ctr #(.W(CNT_W)) u_len (
    .clk(clk), .rst(rst), .load(wr_count), .load_val(wdata[CNT_W-1:0]),
    .dec(do_xfer), .cnt(cur_count), .is_one(cnt_one), .is_zero(cnt_zero)
  );

  assign do_xfer = (st_q == ST_XFER) && fifo_ready && chan_en;
  assign tc_hit  = do_xfer && cnt_one && !wr_count;

  always_comb begin
    en_n     = chan_en;
    dec_n    = dec_q;
    irq_en_n = irq_en_q;
    if (wr_ctrl) begin
      en_n     = wdata[CTL_EN] && !cnt_zero;
      dec_n    = wdata[CTL_DEC];
      irq_en_n = wdata[CTL_IRQEN];
    end
    if (tc_hit || abort_req) en_n = 1'b0;

    tc_n  = tc_hit    || (tc_flag    && !(wr_clr && wdata[CLR_TC]));
    abt_n = abort_req || (abort_flag && !(wr_clr && wdata[CLR_ABT]));

    st_n    = st_q;
    drain_n = 1'b0;
    unique case (st_q)
      ST_IDLE: if (bus_req && bus_grant) st_n = ST_XFER;
      ST_XFER: begin
        if (!fifo_ready) begin
          st_n    = ST_IDLE;
          drain_n = 1'b1;
        end else if (tc_hit || fifo_last) begin
          st_n    = ST_COOL;
          drain_n = fifo_last;
        end else begin
          st_n = ST_GAP;
        end
      end
      ST_GAP:  st_n = ST_XFER;
      ST_COOL: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    if (!en_n && (st_n == ST_XFER || st_n == ST_GAP))
      st_n = do_xfer ? ST_COOL : ST_IDLE;

    in_service_n = (st_n == ST_XFER) || (st_n == ST_GAP);
    req_n = en_n && (in_service_n ||
                     (st_n == ST_IDLE && st_q == ST_IDLE && fifo_ready));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      chan_en      <= 1'b0;
      dec_q        <= 1'b0;
      irq_en_q     <= 1'b0;
      tc_flag      <= 1'b0;
      abort_flag   <= 1'b0;
      irq          <= 1'b0;
      bus_req      <= 1'b0;
      xfer_valid   <= 1'b0;
      xfer_addr    <= '0;
      fifo_drained <= 1'b0;
    end else begin
      st_q         <= st_n;
      chan_en      <= en_n;
      dec_q        <= dec_n;
      irq_en_q     <= irq_en_n;
      tc_flag      <= tc_n;
      abort_flag   <= abt_n;
      irq          <= tc_n && irq_en_n;
      bus_req      <= req_n;
      xfer_valid   <= do_xfer;
      fifo_drained <= drain_n && do_xfer;
      if (do_xfer) xfer_addr <= cur_addr;
    end
  end
endmodule

// File: rtl/fdma_chan_chk.sv
module fdma_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_addr,
  input logic              wr_count,
  input logic              wr_ctrl,
  input logic              xfer_valid,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [CNT_W-1:0]  cur_count,
  input logic              bus_req,
  input logic              chan_en,
  input logic              tc_flag,
  input logic              abort_flag,
  input logic              irq,
  input logic              dec_q
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  C1 = CNT_W'(1);

  assert_req_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> chan_en);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !$past(wr_addr) && !$past(wr_ctrl)) |->
      (cur_addr == (dec_q ? xfer_addr - A1 : xfer_addr + A1)));

  assert_xfer_gap_R4: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |=> !xfer_valid);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !$past(wr_count)) |-> (cur_count == $past(cur_count) - C1));

  assert_tc_stops_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tc_flag) |-> (!chan_en && !bus_req));

  assert_irq_src_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> tc_flag);

  assert_abort_stops_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_flag) |=> !xfer_valid);
endmodule

bind flyby_dma_chan fdma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_count(wr_count),
  .wr_ctrl(wr_ctrl), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
  .cur_addr(cur_addr), .cur_count(cur_count), .bus_req(bus_req),
  .chan_en(chan_en), .tc_flag(tc_flag), .abort_flag(abort_flag),
  .irq(irq), .dec_q(dec_q)
);

// File: tb/flyby_dma_chan_tb.sv
module flyby_dma_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 0, rst = 1;
  logic wr_addr = 0, wr_count = 0, wr_ctrl = 0, wr_clr = 0;
  logic [AW-1:0] wdata = '0;
  logic abort_req = 0, bus_grant = 1;
  logic fifo_ready, fifo_last;
  logic bus_req, xfer_valid, fifo_drained, tc_flag, abort_flag, irq, chan_en;
  logic [AW-1:0] xfer_addr, cur_addr;
  logic [CW-1:0] cur_count;

  int fifo_cnt = 0;
  logic fifo_wr = 0;
  int fifo_wval = 0;
  int tests = 0, fails = 0;
  int xfer_seen = 0;
  bit drain_seen = 0;
  bit done = 0;
  logic [AW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flyby_dma_chan #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_count(wr_count),
    .wr_ctrl(wr_ctrl), .wr_clr(wr_clr), .wdata(wdata), .abort_req(abort_req),
    .fifo_ready(fifo_ready), .fifo_last(fifo_last), .bus_grant(bus_grant),
    .bus_req(bus_req), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
    .fifo_drained(fifo_drained), .tc_flag(tc_flag), .abort_flag(abort_flag),
    .irq(irq), .chan_en(chan_en), .cur_addr(cur_addr), .cur_count(cur_count)
  );

  // FIFO model: popped by each transfer strobe
  assign fifo_ready = (fifo_cnt > 0);
  assign fifo_last  = (fifo_cnt == 1);
  always @(posedge clk) begin
    if (fifo_wr) fifo_cnt <= fifo_wval;
    else if (xfer_valid && fifo_cnt > 0) fifo_cnt <= fifo_cnt - 1;
  end

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard of transfer addresses
  always @(negedge clk) begin
    if (!rst) begin
      if (fifo_drained) drain_seen = 1;
      if (xfer_valid) begin
        xfer_seen++;
        if (exp_q.size() == 0) check(0, "R3 unexpected transfer", xfer_addr, '0);
        else begin
          logic [AW-1:0] e;
          e = exp_q.pop_front();
          check(xfer_addr == e, "R3 transfer address", xfer_addr, e);
        end
      end
    end
  end

  task automatic sw(input int kind, input logic [AW-1:0] d);
    @(negedge clk);
    wdata = d;
    case (kind)
      0: wr_addr = 1;
      1: wr_count = 1;
      2: wr_ctrl = 1;
      default: wr_clr = 1;
    endcase
    @(negedge clk);
    wr_addr = 0; wr_count = 0; wr_ctrl = 0; wr_clr = 0;
  endtask

  task automatic set_fifo(input int n);
    @(negedge clk);
    fifo_wr = 1; fifo_wval = n;
    @(negedge clk);
    fifo_wr = 0;
  endtask

  task automatic push_exp(input logic [AW-1:0] a, input bit dec, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(dec ? a - AW'(i) : a + AW'(i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({bus_req, xfer_valid, fifo_drained, tc_flag, abort_flag, irq, chan_en} == 0,
          "R1 outputs in reset", {bus_req, xfer_valid, tc_flag, irq, chan_en}, 0);
    rst = 0;
    @(negedge clk);
    check(cur_addr == 0 && cur_count == 0 && !bus_req, "R1 after reset",
          cur_addr | AW'(cur_count), 0);

    // R2 no request while disabled
    set_fifo(3);
    repeat (5) @(negedge clk);
    check(!bus_req && xfer_seen == 0, "R2 disabled no request", AW'(bus_req), 0);
    set_fifo(0);

    // R3/R5/R6 increment burst, FIFO drains before count
    sw(0, 32'h1000); sw(1, 10);
    set_fifo(4);
    push_exp(32'h1000, 0, 4);
    drain_seen = 0; xfer_seen = 0;
    @(negedge clk); wdata = 32'h1; wr_ctrl = 1;
    @(negedge clk); wr_ctrl = 0;
    check(bus_req == 1, "R2 request after enable", AW'(bus_req), 1);
    repeat (30) @(negedge clk);
    check(xfer_seen == 4, "R5 drains all FIFO bytes", xfer_seen, 4);
    check(drain_seen, "R5 drain reported", AW'(drain_seen), 1);
    check(!bus_req && chan_en, "R5 bus released, still enabled", {bus_req, chan_en}, 2'b01);
    check(cur_count == 6, "R6 count decremented", AW'(cur_count), 6);
    check(cur_addr == 32'h1004, "R3 next address", cur_addr, 32'h1004);
    // refill: request resumes
    push_exp(32'h1004, 0, 2);
    set_fifo(2);
    repeat (20) @(negedge clk);
    check(cur_count == 4 && exp_q.size() == 0, "R6 resumed burst count", AW'(cur_count), 4);

    // R3 decrement with wrap
    sw(0, 32'h1); sw(1, 10);
    set_fifo(3);
    push_exp(32'h1, 1, 3);
    sw(2, 32'h3);
    repeat (30) @(negedge clk);
    check(cur_addr == 32'hFFFF_FFFE, "R3 decrement wraps", cur_addr, 32'hFFFF_FFFE);
    check(exp_q.size() == 0, "R3 all wrapped addresses seen", exp_q.size(), 0);

    // R7/R8 terminal count before FIFO empty, irq enabled
    sw(0, 32'h2000); sw(1, 2);
    set_fifo(5);
    push_exp(32'h2000, 0, 2);
    drain_seen = 0;
    sw(2, 32'h5);
    repeat (30) @(negedge clk);
    check(tc_flag && !chan_en && !bus_req, "R7 tc stops channel",
          {tc_flag, chan_en, bus_req}, 3'b100);
    check(fifo_cnt == 3 && cur_count == 0, "R7 exactly count transfers", fifo_cnt, 3);
    check(!drain_seen, "R7 no drain on tc", AW'(drain_seen), 0);
    check(irq, "R8 irq raised", AW'(irq), 1);
    sw(3, 32'h1);
    check(!irq && !tc_flag, "R8 w1c clears tc and irq", {irq, tc_flag}, 0);
    set_fifo(0);

    // R11 tc coincides with last FIFO byte
    sw(0, 32'h3000); sw(1, 3);
    set_fifo(3);
    push_exp(32'h3000, 0, 3);
    drain_seen = 0;
    sw(2, 32'h1);
    repeat (30) @(negedge clk);
    check(tc_flag && drain_seen, "R11 both end conditions", {tc_flag, drain_seen}, 2'b11);
    check(!irq, "R8 no irq when disabled", AW'(irq), 0);
    check(!bus_req, "R11 request dropped", AW'(bus_req), 0);
    sw(3, 32'h1);

    // R10 enable ignored at count zero
    set_fifo(2);
    sw(2, 32'h1);
    repeat (6) @(negedge clk);
    check(!chan_en && !bus_req, "R10 enable ignored at zero", {chan_en, bus_req}, 0);
    set_fifo(0);

    // R9 abort mid-burst
    sw(0, 32'h4000); sw(1, 20);
    set_fifo(10);
    push_exp(32'h4000, 0, 10);
    xfer_seen = 0;
    sw(2, 32'h1);
    repeat (6) @(negedge clk);
    abort_req = 1;
    @(negedge clk);
    abort_req = 0;
    repeat (10) @(negedge clk);
    begin
      int seen;
      seen = xfer_seen;
      check(abort_flag && !chan_en && !bus_req, "R9 abort clears enable",
            {abort_flag, chan_en, bus_req}, 3'b100);
      check(seen < 10 && seen > 0, "R9 burst cut short", seen, 5);
      check(cur_count == CW'(20 - seen), "R9 count matches transfers", AW'(cur_count), 20 - seen);
      exp_q.delete();
      repeat (20) @(negedge clk);
      check(xfer_seen == seen, "R9 no transfer after abort", xfer_seen, seen);
    end
    sw(3, 32'h2);
    check(!abort_flag, "R8 w1c clears abort", AW'(abort_flag), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule